// File: doc/BRIEF.md
# Register Rename Stage with Free-Register Pool

This block renames instructions that arrive in program order. It keeps a table with one physical register number for each architectural register, and that number names the most recent producer. For each accepted instruction the block reads the physical names of its two sources from the table. If the instruction writes a register, it takes a fresh physical register from a pool of unused registers and installs that register in the table as the new producer of the destination. The sources are always read before the same instruction's destination entry is overwritten. Instructions that write no register, such as stores and branches, take nothing from the pool.

Each result also reports the physical register that the destination replaced. The commit logic later hands that old register back through the release port. The register that the committing instruction itself wrote stays mapped. For speculation there is a single checkpoint. It records the table and the pool's read position. A restore returns both to the recorded state, which puts back every register handed out after the checkpoint. The physical register count must be a power of two and larger than the architectural count.

Top module: `reg_rename_unit`

## Requirements
- R1: After reset, architectural register i maps to physical register i. The pool holds physical registers ARCH_REGS up to PHYS_REGS-1, and they are handed out in ascending order.
- R2: The physical source names of an instruction are the table entries as they stood before that instruction's own destination update. A source equal to the destination therefore reads the old mapping.
- R3: An accepted instruction with a destination receives the register at the front of the pool as `out_pdst_o`. It receives the destination's previous mapping as `out_pold_o`. Later instructions see the new mapping from the next cycle on.
- R4: An instruction with `ren_has_dst_i` low allocates nothing and leaves the table unchanged. Its result shows `out_pdst_o` = 0 and `out_pold_o` = 0.
- R5: An instruction accepted in cycle t (`ren_valid_i` and `ren_ready_o` both high) appears with `out_valid_o` high after the clock edge that ends cycle t. `out_valid_o` is low otherwise.
- R6: `ren_ready_o` is low when the pool is empty and the offered instruction has a destination. It is high for an instruction without a destination, or when the pool is not empty, unless a restore is requested.
- R7: A pulse on `cmt_valid_i` appends `cmt_preg_i` to the back of the pool. Released registers are handed out again in first-in, first-out order after those already waiting.
- R8: `ckpt_take_i` records the table and the pool read position as they stood before any rename accepted in the same cycle. That rename therefore belongs to the speculative part.
- R9: `restore_i` returns the table and the pool read position to the recorded state. `ren_ready_o` is low in a restore cycle. A restore takes priority over a checkpoint in the same cycle.
- R10: A release in the same cycle as a rename or a restore takes effect in full. The released register goes to the back of the pool, which is not rolled back by the restore.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ren_valid_i | input | 1 | Instruction offered for renaming |
| ren_ready_o | output | 1 | Instruction can be accepted this cycle |
| ren_src0_i | input | AW | First architectural source |
| ren_src1_i | input | AW | Second architectural source |
| ren_dst_i | input | AW | Architectural destination |
| ren_has_dst_i | input | 1 | Instruction writes a register |
| out_valid_o | output | 1 | Renamed result valid |
| out_psrc0_o | output | PW | Physical name of first source |
| out_psrc1_o | output | PW | Physical name of second source |
| out_has_dst_o | output | 1 | Result carries a destination |
| out_pdst_o | output | PW | Newly allocated physical destination |
| out_pold_o | output | PW | Previous mapping of the destination |
| cmt_valid_i | input | 1 | Release a physical register |
| cmt_preg_i | input | PW | Physical register being released |
| ckpt_take_i | input | 1 | Record a checkpoint |
| restore_i | input | 1 | Roll back to the checkpoint |

## Verification
A release can land in the same cycle as a rename that draws from the pool, and also in the same cycle as a restore. In the first case the pool is read at the front and written at the back at once. In the second case the read position jumps back while the write position keeps moving forward. The bench provokes both by issuing releases on random cycles during long rename streams with checkpoints and restores, and by running the pool down to empty. A queue-based model in the bench predicts every allocation. A register handed out twice, or one lost across a restore, shows up as a wrong `out_pdst_o` some cycles later.

// File: rtl/rn_pkg.sv
package rn_pkg;
  localparam int ARCH_REGS_DEF = 16;
  localparam int PHYS_REGS_DEF = 32;

  function automatic int idx_bits(input int n);
    int b;
    b = 1;
    while ((1 << b) < n) b++;
    return b;
  endfunction
endpackage

// File: rtl/rn_map_table.sv
module rn_map_table
  import rn_pkg::*;
#(
  parameter int ARCH_REGS = ARCH_REGS_DEF,
  parameter int PHYS_REGS = PHYS_REGS_DEF,
  localparam int AW = idx_bits(ARCH_REGS),
  localparam int PW = idx_bits(PHYS_REGS)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] rd0_idx,
  input  logic [AW-1:0] rd1_idx,
  input  logic [AW-1:0] rdd_idx,
  output logic [PW-1:0] rd0_val,
  output logic [PW-1:0] rd1_val,
  output logic [PW-1:0] rdd_val,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_idx,
  input  logic [PW-1:0] wr_val,
  input  logic          ckpt,
  input  logic          restore
);
  logic [PW-1:0] map_q  [ARCH_REGS];
  logic [PW-1:0] snap_q [ARCH_REGS];

  // lookups see the table before this cycle's write lands
  assign rd0_val = map_q[rd0_idx];
  assign rd1_val = map_q[rd1_idx];
  assign rdd_val = map_q[rdd_idx];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < ARCH_REGS; i++) begin
        map_q[i]  <= PW'(i);
        snap_q[i] <= PW'(i);
      end
    end else if (restore) begin
      for (int i = 0; i < ARCH_REGS; i++) map_q[i] <= snap_q[i];
    end else begin
      if (ckpt) begin
        for (int i = 0; i < ARCH_REGS; i++) snap_q[i] <= map_q[i];
      end
      if (wr_en) map_q[wr_idx] <= wr_val;
    end
  end

  AST_WRITE_NOT_ON_RESTORE: assert property (@(posedge clk) disable iff (rst)
    restore |-> !wr_en); // R9
endmodule

// File: rtl/rn_free_list.sv
module rn_free_list
  import rn_pkg::*;
#(
  parameter int ARCH_REGS = ARCH_REGS_DEF,
  parameter int PHYS_REGS = PHYS_REGS_DEF,
  localparam int PW    = idx_bits(PHYS_REGS),
  localparam int PTRW  = PW + 1,
  localparam int NFREE = PHYS_REGS - ARCH_REGS
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          pop,
  output logic [PW-1:0] head_val,
  output logic          empty,
  input  logic          push,
  input  logic [PW-1:0] push_val,
  input  logic          ckpt,
  input  logic          restore
);
  logic [PW-1:0]   mem_q [PHYS_REGS];
  logic [PTRW-1:0] head_q, tail_q, snap_head_q;
  logic [PTRW-1:0] count;

  assign count    = tail_q - head_q;
  assign empty    = (count == '0);
  assign head_val = mem_q[head_q[PW-1:0]];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < PHYS_REGS; k++)
        mem_q[k] <= (k < NFREE) ? PW'(ARCH_REGS + k) : '0;
      tail_q <= PTRW'(NFREE);
    end else if (push) begin
      mem_q[tail_q[PW-1:0]] <= push_val;
      tail_q <= tail_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      head_q      <= '0;
      snap_head_q <= '0;
    end else if (restore) begin
      head_q <= snap_head_q;
    end else begin
      if (ckpt) snap_head_q <= head_q;
      if (pop)  head_q      <= head_q + 1'b1;
    end
  end

  AST_POP_NONEMPTY: assert property (@(posedge clk) disable iff (rst)
    pop |-> !empty); // R6
  AST_FREE_BOUND: assert property (@(posedge clk) disable iff (rst)
    count <= PTRW'(NFREE)); // R7
endmodule

// File: rtl/reg_rename_unit.sv
module reg_rename_unit
  import rn_pkg::*;
#(
  parameter int ARCH_REGS = ARCH_REGS_DEF,
  parameter int PHYS_REGS = PHYS_REGS_DEF,
  localparam int AW = idx_bits(ARCH_REGS),
  localparam int PW = idx_bits(PHYS_REGS)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ren_valid_i,
  output logic          ren_ready_o,
  input  logic [AW-1:0] ren_src0_i,
  input  logic [AW-1:0] ren_src1_i,
  input  logic [AW-1:0] ren_dst_i,
  input  logic          ren_has_dst_i,
  output logic          out_valid_o,
  output logic [PW-1:0] out_psrc0_o,
  output logic [PW-1:0] out_psrc1_o,
  output logic          out_has_dst_o,
  output logic [PW-1:0] out_pdst_o,
  output logic [PW-1:0] out_pold_o,
  input  logic          cmt_valid_i,
  input  logic [PW-1:0] cmt_preg_i,
  input  logic          ckpt_take_i,
  input  logic          restore_i
);
  logic          fl_empty;
  logic [PW-1:0] fl_head;
  logic [PW-1:0] ps0, ps1, pold;
  logic          accept, alloc, ckpt_eff;

  assign ren_ready_o = !restore_i && (!ren_has_dst_i || !fl_empty);
  assign accept      = ren_valid_i && ren_ready_o;
  assign alloc       = accept && ren_has_dst_i;
  assign ckpt_eff    = ckpt_take_i && !restore_i;

  rn_map_table #(.ARCH_REGS(ARCH_REGS), .PHYS_REGS(PHYS_REGS)) map_i (
    .clk     (clk),
    .rst     (rst),
    .rd0_idx (ren_src0_i),
    .rd1_idx (ren_src1_i),
    .rdd_idx (ren_dst_i),
    .rd0_val (ps0),
    .rd1_val (ps1),
    .rdd_val (pold),
    .wr_en   (alloc),
    .wr_idx  (ren_dst_i),
    .wr_val  (fl_head),
    .ckpt    (ckpt_eff),
    .restore (restore_i)
  );

  rn_free_list #(.ARCH_REGS(ARCH_REGS), .PHYS_REGS(PHYS_REGS)) pool_i (
    .clk      (clk),
    .rst      (rst),
    .pop      (alloc),
    .head_val (fl_head),
    .empty    (fl_empty),
    .push     (cmt_valid_i),
    .push_val (cmt_preg_i),
    .ckpt     (ckpt_eff),
    .restore  (restore_i)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid_o   <= 1'b0;
      out_psrc0_o   <= '0;
      out_psrc1_o   <= '0;
      out_has_dst_o <= 1'b0;
      out_pdst_o    <= '0;
      out_pold_o    <= '0;
    end else begin
      out_valid_o <= accept;
      if (accept) begin
        out_psrc0_o   <= ps0;
        out_psrc1_o   <= ps1;
        out_has_dst_o <= ren_has_dst_i;
        out_pdst_o    <= ren_has_dst_i ? fl_head : '0;
        out_pold_o    <= ren_has_dst_i ? pold : '0;
      end
    end
  end

  AST_NEW_NOT_OLD: assert property (@(posedge clk) disable iff (rst)
    out_valid_o && out_has_dst_o |-> out_pdst_o != out_pold_o); // R3
  AST_NEW_NOT_SOURCE: assert property (@(posedge clk) disable iff (rst)
    out_valid_o && out_has_dst_o |-> (out_pdst_o != out_psrc0_o) && (out_pdst_o != out_psrc1_o)); // R2
  AST_NODST_BLANK: assert property (@(posedge clk) disable iff (rst)
    out_valid_o && !out_has_dst_o |-> out_pdst_o == '0 && out_pold_o == '0); // R4
  AST_RESTORE_NO_RESULT: assert property (@(posedge clk) disable iff (rst)
    restore_i |=> !out_valid_o); // R9
endmodule

// File: tb/reg_rename_unit_tb_top.sv
`timescale 1ns/1ps
module reg_rename_unit_tb_top;
  localparam int ARCH = 16;
  localparam int PHYS = 32;
  localparam int AW = 4;
  localparam int PW = 5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;

  logic          ren_valid_i = 0, ren_has_dst_i = 0;
  logic [AW-1:0] ren_src0_i = 0, ren_src1_i = 0, ren_dst_i = 0;
  logic          cmt_valid_i = 0, ckpt_take_i = 0, restore_i = 0;
  logic [PW-1:0] cmt_preg_i = 0;
  logic          ren_ready_o, out_valid_o, out_has_dst_o;
  logic [PW-1:0] out_psrc0_o, out_psrc1_o, out_pdst_o, out_pold_o;

  reg_rename_unit #(.ARCH_REGS(ARCH), .PHYS_REGS(PHYS)) dut_i (.*);

  int total = 0, bad = 0;
  bit finished = 0;

  int map_m[ARCH], snap_m[ARCH];
  int free_q[$], since_q[$], pend_q[$], young_q[$];
  bit in_spec = 0;
  bit e_valid = 0, e_hd = 0;
  int e_ps0, e_ps1, e_pd, e_pold;

  task automatic chk(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic step(bit v, int s0, int s1, int d, bit hd, bit cm, bit ck, bit rs, string tag);
    bit rdy, acc;
    int cval;
    @(negedge clk);
    chk("R5 out_valid", out_valid_o, e_valid);
    if (e_valid) begin
      chk("R2 psrc0", out_psrc0_o, e_ps0);
      chk("R2 psrc1", out_psrc1_o, e_ps1);
      chk(hd ? "R3 has_dst" : "R4 has_dst", out_has_dst_o, e_hd);
      chk({tag, " pdst"}, out_pdst_o, e_pd);
      chk(e_hd ? "R3 pold" : "R4 pold", out_pold_o, e_pold);
    end
    if (cm && pend_q.size() == 0) cm = 0;
    cval = cm ? pend_q.pop_front() : 0;
    ren_valid_i = v; ren_src0_i = AW'(s0); ren_src1_i = AW'(s1);
    ren_dst_i = AW'(d); ren_has_dst_i = hd;
    cmt_valid_i = cm; cmt_preg_i = PW'(cval);
    ckpt_take_i = ck; restore_i = rs;
    #1;
    rdy = !rs && (!hd || free_q.size() > 0);
    chk(rs ? "R9 ready" : "R6 ready", ren_ready_o, rdy);
    acc = v && rdy;
    if (rs) begin
      map_m = snap_m;
      for (int i = since_q.size() - 1; i >= 0; i--) free_q.push_front(since_q[i]);
      since_q.delete();
      young_q.delete();
      in_spec = 0;
    end else if (ck) begin
      snap_m = map_m;
      since_q.delete();
      in_spec = 1;
    end
    e_valid = acc;
    if (acc) begin
      e_ps0 = map_m[s0]; e_ps1 = map_m[s1]; e_hd = hd;
      e_pd = 0; e_pold = 0;
      if (hd) begin
        e_pd = free_q.pop_front();
        e_pold = map_m[d];
        map_m[d] = e_pd;
        since_q.push_back(e_pd);
        if (in_spec) young_q.push_back(e_pold); else pend_q.push_back(e_pold);
      end
    end
    if (cm) free_q.push_back(cval);
  endtask

  task automatic idle();
    step(0, 0, 0, 0, 0, 0, 0, 0, "R5");
  endtask

  task automatic rand_phase(int n, int p_cm, int p_ck, int p_rs, string tag);
    for (int c = 0; c < n; c++) begin
      bit ck, rs;
      ck = !in_spec && ($urandom_range(99) < p_ck);
      rs = in_spec && ($urandom_range(99) < p_rs);
      step($urandom_range(3) != 0, $urandom_range(ARCH-1), $urandom_range(ARCH-1),
           $urandom_range(ARCH-1), $urandom_range(4) != 0,
           $urandom_range(99) < p_cm, ck, rs, tag);
    end
  endtask

  initial begin
    #(20 * 200000);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog act=0 exp=1");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < ARCH; i++) begin map_m[i] = i; snap_m[i] = i; end
    for (int k = ARCH; k < PHYS; k++) free_q.push_back(k);
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;
    // R1: reset state
    chk("R1 reset out_valid", out_valid_o, 0);
    ren_has_dst_i = 1; #1;
    chk("R1 reset ready", ren_ready_o, 1);
    // R1 / R2: identity mapping, source equal to destination reads old name
    step(1, 3, 5, 3, 1, 0, 0, 0, "R1");
    step(1, 3, 3, 7, 1, 0, 0, 0, "R1");
    step(1, 7, 3, 0, 0, 0, 0, 0, "R4");
    idle();
    // R6: drain the pool with no releases, then a no-destination instruction
    for (int c = 0; c < 18; c++) step(1, c % ARCH, 0, c % ARCH, 1, 0, 0, 0, "R6");
    step(1, 2, 4, 9, 0, 0, 0, 0, "R4");
    // R7: releases refill the pool in FIFO order
    for (int c = 0; c < 6; c++) step(0, 0, 0, 0, 0, 1, 0, 0, "R7");
    for (int c = 0; c < 8; c++) step(1, c, c + 1, c + 2, 1, 1, 0, 0, "R7");
    // R8: checkpoint in the same cycle as a rename, then restore
    step(1, 2, 2, 2, 1, 1, 1, 0, "R8");
    step(1, 2, 1, 2, 1, 0, 0, 0, "R8");
    step(1, 2, 1, 2, 1, 1, 0, 1, "R9");
    step(1, 2, 2, 2, 1, 0, 0, 0, "R8");
    idle();
    // R7 / R10: random streams with releases, checkpoints and restores
    rand_phase(400, 40, 0, 0, "R7");
    rand_phase(800, 50, 15, 20, "R9");
    rand_phase(600, 90, 30, 40, "R10");
    rand_phase(300, 10, 10, 10, "R6");
    idle(); idle();
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule